// File: doc/BRIEF.md
# Per-Thread Issue Queue Share Limiter

This block does the occupancy bookkeeping for an issue queue that several hardware threads share. It counts how many entries each thread holds and applies a per-thread ceiling, called the cap. Each cycle it takes at most one allocate strobe and at most one release strobe, each tagged with a thread number. It reports, for every thread, how many more entries that thread may take and whether it is full. It also reports the free count of the whole queue and whether the queue is full. The queue storage and the choice of which thread to dispatch belong to the surrounding logic. That logic reads the full flags before it dispatches.

The caps follow one of three sharing schemes, chosen by a static select:
- **Dynamic:** every thread may use the whole queue.
- **Partitioned:** the queue is split evenly among the threads.
- **Threshold:** each thread may use a set percentage of the queue.

At reset the caps are loaded from the selected scheme. When the active-thread mask changes, the caps are recomputed at the next clock edge. A cap that falls below a thread's current holding never evicts entries; the thread simply reads as full until releases bring it back under its cap. An allocate that the block cannot honour is dropped, and a sticky error flag records it.

Top module: `smt_iq_share_limiter`

## Requirements
- R1: While `rst_n` is low, at every clock edge every thread's occupancy clears, the global free count loads `CAPACITY`, `alloc_err` clears and the caps load from the policy (R2 to R4). After reset, the first active mask counts as a change for R5 and R6.
- R2: Policy encoding 2'b00 (dynamic) gives every thread a cap of `CAPACITY`. Encoding 2'b11 behaves exactly like 2'b00.
- R3: Policy encoding 2'b01 (partitioned) loads each thread's cap at reset with `CAPACITY / THREADS`, truncated.
- R4: Policy encoding 2'b10 (threshold) loads each thread's cap at reset with `CAPACITY * p / 100`, truncated, where p is `thresh_pct` with values above 100 treated as 100.
- R5: Under the partitioned policy, one edge after `active_mask` differs from its previous value, each thread whose mask bit is 1 gets a cap of `CAPACITY` divided by the number of set bits, truncated. Threads whose bit is 0 keep their caps. An all-zero mask changes no cap.
- R6: Under the threshold policy, one edge after a mask change that leaves exactly one bit set, that thread's cap becomes `CAPACITY`. Every other thread keeps its cap.
- R7: A thread's free count is its cap minus its occupancy, saturating at 0. The thread's `thr_full` bit is 1 exactly when that free count is 0. Thread t occupies bits [t*CW +: CW] of `thr_free`, where CW = clog2(CAPACITY+1).
- R8: `glob_free` equals `CAPACITY` minus the sum of all occupancies. `glob_full` is 1 exactly when `glob_free` is 0, whatever the caps allow.
- R9: An allocate is ignored if its thread is full, if the queue is globally full, or if the thread number is out of range. An ignored allocate changes no count and sets `alloc_err`, which stays set until reset.
- R10: An allocate and a release in the same cycle are both applied, whether they name the same thread or different threads. Acceptance of the allocate is judged on the state before that cycle.
- R11: A cap that drops below a thread's occupancy removes no entries. The thread's occupancy and the global free count stay unchanged, and the thread reads full until releases bring its occupancy under the cap.
- R12: A release for a thread that holds no entries is ignored and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_sel | input | 2 | Sharing scheme: 00 dynamic, 01 partitioned, 10 threshold, 11 dynamic |
| thresh_pct | input | PCTW | Threshold percentage, clamped to 100 |
| active_mask | input | THREADS | One bit per active thread |
| alloc_valid | input | 1 | Allocate one entry this cycle |
| alloc_tid | input | TIDW | Thread that takes the entry |
| rel_valid | input | 1 | Release one entry this cycle |
| rel_tid | input | TIDW | Thread that gives back the entry |
| thr_free | output | THREADS*CW | Per-thread free counts, thread t at [t*CW +: CW] |
| thr_full | output | THREADS | Per-thread full flags |
| glob_free | output | CW | Free entries in the whole queue |
| glob_full | output | 1 | Whole queue is full |
| alloc_err | output | 1 | Sticky flag: an allocate was dropped |

## Verification
A table of allocate and release pairs runs under the dynamic policy. It mixes lone allocates, an allocate and a release to different threads, an allocate and a release to the same thread, and releases to empty threads. These cases separate correct same-cycle accounting from designs that drop one of the two strobes or let a release underflow a counter.

Directed sequences then load each policy through reset, including a truncating percentage and one above 100. They walk the partitioned caps through several mask sizes, including the all-zero mask. They drive a thread past its cap and then shrink the cap under its occupancy. This shows that a rebalance touches only active threads, that no entry is evicted, and that the per-thread and global limits reject allocates independently.

// File: rtl/smt_iq_share_limiter.sv
module smt_iq_share_limiter #(
  parameter int THREADS  = 4,
  parameter int CAPACITY = 32,
  parameter int PCTW     = 7,
  localparam int TIDW    = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CW      = $clog2(CAPACITY + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            policy_sel,
  input  logic [PCTW-1:0]       thresh_pct,
  input  logic [THREADS-1:0]    active_mask,
  input  logic                  alloc_valid,
  input  logic [TIDW-1:0]       alloc_tid,
  input  logic                  rel_valid,
  input  logic [TIDW-1:0]       rel_tid,
  output logic [THREADS*CW-1:0] thr_free,
  output logic [THREADS-1:0]    thr_full,
  output logic [CW-1:0]         glob_free,
  output logic                  glob_full,
  output logic                  alloc_err
);

  localparam int NW = $clog2(THREADS + 1);
  localparam logic [1:0] POL_PART = 2'b01;
  localparam logic [1:0] POL_THR  = 2'b10;

  typedef logic [CW-1:0] cnt_t;

  cnt_t               cap_q [THREADS];
  cnt_t               occ_q [THREADS];
  cnt_t               cap_d [THREADS];
  cnt_t               total_q;
  logic [THREADS-1:0] prev_mask_q;
  logic               err_q;

  logic [NW-1:0]      act_cnt;
  logic               mask_chg;
  cnt_t               part_cap;
  cnt_t               reset_cap;
  logic [THREADS-1:0] a_hit, r_hit;
  logic               acc, rel_any;

  function automatic cnt_t base_cap(input logic [1:0] pol, input logic [PCTW-1:0] pct);
    int p;
    p = (int'(pct) > 100) ? 100 : int'(pct);
    case (pol)
      POL_PART: return cnt_t'(CAPACITY / THREADS);
      POL_THR:  return cnt_t'((CAPACITY * p) / 100);
      default:  return cnt_t'(CAPACITY);
    endcase
  endfunction

  assign reset_cap = base_cap(policy_sel, thresh_pct);
  assign mask_chg  = active_mask != prev_mask_q;

  always_comb begin
    act_cnt = '0;
    for (int t = 0; t < THREADS; t++) act_cnt = act_cnt + NW'(active_mask[t]);
  end

  assign part_cap = (act_cnt == '0) ? '0 : cnt_t'(CAPACITY / int'(act_cnt));

  always_comb begin
    for (int t = 0; t < THREADS; t++) begin
      cap_d[t] = cap_q[t];
      if (mask_chg && active_mask[t]) begin
        if (policy_sel == POL_PART) cap_d[t] = part_cap;
        else if (policy_sel == POL_THR && act_cnt == NW'(1)) cap_d[t] = cnt_t'(CAPACITY);
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < THREADS; g++) begin : g_thr
      assign thr_full[g]           = occ_q[g] >= cap_q[g];
      assign thr_free[g*CW +: CW]  = thr_full[g] ? '0 : cap_q[g] - occ_q[g];
      assign a_hit[g]              = alloc_valid && (alloc_tid == TIDW'(g));
      assign r_hit[g]              = rel_valid && (rel_tid == TIDW'(g)) && (occ_q[g] != '0);
    end
  endgenerate

  assign glob_free = cnt_t'(CAPACITY) - total_q;
  assign glob_full = glob_free == '0;
  assign acc       = |(a_hit & ~thr_full) && !glob_full;
  assign rel_any   = |r_hit;
  assign alloc_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < THREADS; t++) begin
        cap_q[t] <= reset_cap;
        occ_q[t] <= '0;
      end
      total_q     <= '0;
      prev_mask_q <= '0;
      err_q       <= 1'b0;
    end else begin
      for (int t = 0; t < THREADS; t++) begin
        cap_q[t] <= cap_d[t];
        occ_q[t] <= occ_q[t] + cnt_t'(acc && a_hit[t]) - cnt_t'(r_hit[t]);
      end
      total_q     <= total_q + cnt_t'(acc) - cnt_t'(rel_any);
      prev_mask_q <= active_mask;
      if (alloc_valid && !acc) err_q <= 1'b1;
    end
  end

  logic [31:0] occ_sum;
  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < THREADS; t++) occ_sum = occ_sum + 32'(occ_q[t]);
  end

  p_sum_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(total_q) == occ_sum);

  p_total_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(total_q) <= 32'(CAPACITY));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |=> alloc_err);

  p_full_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && glob_full && !rel_valid) |=> (glob_full && alloc_err));

  generate
    for (g = 0; g < THREADS; g++) begin : g_chk
      p_no_evict_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rel_valid && rel_tid == TIDW'(g)) |=> occ_q[g] >= $past(occ_q[g]));
      p_dyn_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_sel == 2'b00) |-> cap_q[g] == cnt_t'(CAPACITY));
    end
  endgenerate

endmodule

// File: tb/smt_iq_share_limiter_tb_top.sv
module smt_iq_share_limiter_tb_top;
  localparam int THREADS = 4;
  localparam int CAP     = 32;
  localparam int CW      = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst_n = 1'b0;
  logic [1:0]            policy_sel = 2'b00;
  logic [6:0]            thresh_pct = 7'd50;
  logic [THREADS-1:0]    active_mask = 4'b1111;
  logic                  alloc_valid = 1'b0;
  logic [1:0]            alloc_tid = '0;
  logic                  rel_valid = 1'b0;
  logic [1:0]            rel_tid = '0;
  logic [THREADS*CW-1:0] thr_free;
  logic [THREADS-1:0]    thr_full;
  logic [CW-1:0]         glob_free;
  logic                  glob_full;
  logic                  alloc_err;

  smt_iq_share_limiter #(.THREADS(THREADS), .CAPACITY(CAP), .PCTW(7)) dut_i (
    .clk, .rst_n, .policy_sel, .thresh_pct, .active_mask,
    .alloc_valid, .alloc_tid, .rel_valid, .rel_tid,
    .thr_free, .thr_full, .glob_free, .glob_full, .alloc_err);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // {alloc_v, alloc_tid, rel_v, rel_tid, expected glob_free, expected alloc_err}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 2'd0, 1'b0, 2'd0, 6'd31, 1'b0},
    {1'b1, 2'd1, 1'b0, 2'd0, 6'd30, 1'b0},
    {1'b1, 2'd1, 1'b1, 2'd0, 6'd30, 1'b0},
    {1'b1, 2'd2, 1'b1, 2'd2, 6'd29, 1'b0},
    {1'b0, 2'd0, 1'b1, 2'd1, 6'd30, 1'b0},
    {1'b1, 2'd3, 1'b1, 2'd3, 6'd29, 1'b0},
    {1'b1, 2'd3, 1'b1, 2'd3, 6'd29, 1'b0},
    {1'b0, 2'd0, 1'b1, 2'd0, 6'd29, 1'b0}
  };

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int fr(input int t);
    return int'(thr_free[t*CW +: CW]);
  endfunction

  task automatic alloc(input int t);
    alloc_valid = 1'b1; alloc_tid = 2'(t);
    cyc();
    alloc_valid = 1'b0;
  endtask

  task automatic release_one(input int t);
    rel_valid = 1'b1; rel_tid = 2'(t);
    cyc();
    rel_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int m_occ [THREADS];
    // R1 R2: dynamic reset state
    rst_n = 1'b0; policy_sel = 2'b00;
    cyc(); cyc();
    chk("R1", "glob_free", int'(glob_free), CAP);
    chk("R1", "alloc_err", int'(alloc_err), 0);
    chk("R2", "free t3 dynamic", fr(3), CAP);
    policy_sel = 2'b11; cyc();
    chk("R2", "free t1 encoding 11", fr(1), CAP);
    policy_sel = 2'b00; cyc();
    rst_n = 1'b1; cyc();

    // vector table, dynamic policy: R10 same-cycle strobes, R12 empty releases
    for (int t = 0; t < THREADS; t++) m_occ[t] = 0;
    for (int v = 0; v < 8; v++) begin
      int at, rt;
      bit a, r, rok;
      a = VEC[v][12]; at = int'(VEC[v][11:10]);
      r = VEC[v][9];  rt = int'(VEC[v][8:7]);
      rok = r && m_occ[rt] > 0;
      alloc_valid = a; alloc_tid = 2'(at);
      rel_valid = r;   rel_tid = 2'(rt);
      cyc();
      alloc_valid = 1'b0; rel_valid = 1'b0;
      if (a) m_occ[at]++;
      if (rok) m_occ[rt]--;
      chk("R10", $sformatf("vec %0d glob_free", v), int'(glob_free), int'(VEC[v][6:1]));
      chk("R9", $sformatf("vec %0d alloc_err", v), int'(alloc_err), int'(VEC[v][0]));
      for (int t = 0; t < THREADS; t++)
        chk("R12", $sformatf("vec %0d free t%0d", v, t), fr(t), CAP - m_occ[t]);
    end

    // R8 R9: global full
    rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
    for (int i = 0; i < CAP; i++) alloc(i % THREADS);
    chk("R8", "glob_free at full", int'(glob_free), 0);
    chk("R8", "glob_full", int'(glob_full), 1);
    chk("R8", "t0 not full by cap", int'(thr_full[0]), 0);
    alloc(0);
    chk("R9", "err after global reject", int'(alloc_err), 1);
    chk("R9", "glob_free after reject", int'(glob_free), 0);
    release_one(1);
    chk("R9", "err sticky", int'(alloc_err), 1);
    chk("R8", "glob_free after release", int'(glob_free), 1);

    // partitioned: R3 R5 R7 R9 R11
    rst_n = 1'b0; policy_sel = 2'b01; active_mask = 4'b1111; cyc();
    chk("R3", "free t2 partitioned", fr(2), 8);
    chk("R1", "err cleared", int'(alloc_err), 0);
    rst_n = 1'b1; cyc();
    for (int i = 0; i < 8; i++) alloc(0);
    chk("R7", "free t0", fr(0), 0);
    chk("R7", "full t0", int'(thr_full[0]), 1);
    alloc(0);
    chk("R9", "err after thread reject", int'(alloc_err), 1);
    chk("R9", "glob_free unchanged", int'(glob_free), 24);
    active_mask = 4'b0011; cyc();
    chk("R5", "free t0 two active", fr(0), 8);
    chk("R5", "free t1 two active", fr(1), 16);
    chk("R5", "free t3 inactive keeps", fr(3), 8);
    active_mask = 4'b0111; cyc();
    chk("R5", "free t0 three active", fr(0), 2);
    chk("R5", "free t2 three active", fr(2), 10);
    chk("R5", "free t3 still kept", fr(3), 8);
    alloc(0); alloc(0);
    active_mask = 4'b1111; cyc();
    chk("R11", "free t0 over cap", fr(0), 0);
    chk("R11", "full t0 over cap", int'(thr_full[0]), 1);
    chk("R11", "glob_free no evict", int'(glob_free), 22);
    active_mask = 4'b0000; cyc();
    chk("R5", "free t1 zero mask", fr(1), 8);
    release_one(0); release_one(0);
    chk("R11", "full t0 at cap", int'(thr_full[0]), 1);
    release_one(0);
    chk("R11", "free t0 under cap", fr(0), 1);
    chk("R11", "full t0 cleared", int'(thr_full[0]), 0);
    alloc_valid = 1'b1; alloc_tid = 2'd1; rel_valid = 1'b1; rel_tid = 2'd0;
    cyc();
    alloc_valid = 1'b0; rel_valid = 1'b0;
    chk("R10", "free t0 mixed", fr(0), 2);
    chk("R10", "free t1 mixed", fr(1), 7);
    chk("R10", "glob_free mixed", int'(glob_free), 25);

    // threshold: R4 R6
    rst_n = 1'b0; policy_sel = 2'b10; active_mask = 4'b1111; thresh_pct = 7'd37; cyc();
    chk("R4", "free t0 37 pct", fr(0), 11);
    thresh_pct = 7'd120; cyc();
    chk("R4", "free t0 clamped", fr(0), CAP);
    thresh_pct = 7'd50; cyc();
    chk("R4", "free t3 50 pct", fr(3), 16);
    rst_n = 1'b1; cyc();
    chk("R6", "free t2 four active", fr(2), 16);
    active_mask = 4'b0100; cyc();
    chk("R6", "free t2 sole active", fr(2), CAP);
    chk("R6", "free t0 unchanged", fr(0), 16);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule